// File: doc/BRIEF.md
# Dual-Mode Floating-Point Register File

This block holds the floating-point register state of a processor core: 32 entries of 64 bits, each split into a low 32-bit half and an upper 32-bit half. Three access kinds reach the storage. A single-word access touches the low half only. An upper-half access touches the upper half only and serves paired-single data. A doubleword access moves 64 bits, and its layout depends on a mode input.

With the mode input high, a doubleword uses all 64 bits of the one addressed entry. With it low, a doubleword is spread over an even/odd pair of entries. The odd entry's low half carries bits 63:32 and the even entry's low half carries bits 31:0. The upper halves of the pair take no part in this. Each access kind has two combinational read ports and one synchronous write port. A small bank of 64-bit temporary operand registers sits beside the file. Each of these can be loaded with an immediate value or cleared.

Top module: `fp_regfile`

## Requirements
- R1: After a synchronous active-high reset, every half of all 32 entries reads as zero and every temporary operand register reads as zero.
- R2: A single-word read returns the low half (bits 31:0) of the indexed entry. A single-word write replaces that low half and leaves the upper half unchanged, whatever the mode.
- R3: With `mode64` = 1, a doubleword read returns {upper half, low half} of the indexed entry, and a doubleword write replaces both halves of that entry.
- R4: With `mode64` = 0, a doubleword read returns {low half of entry (idx | 1), low half of entry (idx & ~1)}.
- R5: With `mode64` = 0, a doubleword write puts data bits 63:32 into the low half of the odd entry of the pair and bits 31:0 into the low half of the even entry. The upper halves of both entries are unchanged.
- R6: With `mode64` = 0, index bit 0 plays no part in a doubleword access, so an odd index reaches the same pair as its even partner.
- R7: An upper-half read returns bits 63:32 of the indexed entry, in the low 32 bits of the port. An upper-half write replaces those bits and leaves the low half unchanged.
- R8: When a doubleword write and a single-word or upper-half write hit the same storage half in one cycle, the doubleword data is stored.
- R9: Every read port shows the stored value as it was before any write in the same cycle. A write becomes visible on the cycle after its clock edge.
- R10: A temporary operand register selected by `tmp_sel` takes `tmp_imm` when `tmp_load` = 1 and becomes zero when `tmp_clear` = 1. If both are set, clear wins. A select value at or above the register count changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode64 | input | 1 | 1: whole-entry doubleword; 0: even/odd pair doubleword |
| rd_w_idx | input | 2x5 | Single-word read indices |
| rd_w_data | output | 2x32 | Single-word read data |
| rd_d_idx | input | 2x5 | Doubleword read indices |
| rd_d_data | output | 2x64 | Doubleword read data |
| rd_u_idx | input | 2x5 | Upper-half read indices |
| rd_u_data | output | 2x32 | Upper-half read data |
| wr_w_en | input | 1 | Single-word write enable |
| wr_w_idx | input | 5 | Single-word write index |
| wr_w_data | input | 32 | Single-word write data |
| wr_d_en | input | 1 | Doubleword write enable |
| wr_d_idx | input | 5 | Doubleword write index |
| wr_d_data | input | 64 | Doubleword write data |
| wr_u_en | input | 1 | Upper-half write enable |
| wr_u_idx | input | 5 | Upper-half write index |
| wr_u_data | input | 32 | Upper-half write data |
| tmp_sel | input | 2 | Temporary operand register select |
| tmp_load | input | 1 | Load `tmp_imm` into the selected temporary |
| tmp_clear | input | 1 | Clear the selected temporary |
| tmp_imm | input | 64 | Immediate value for a load |
| tmp_q | output | 3x64 | Temporary operand register contents |

## Verification
A wrong half-select or a wrong pair decode stores data in a half that no port of the right kind expected to change. The fault therefore shows up on the first later read of that half, through any of the three read kinds, one cycle after the write edge. The bench keeps a reference copy of all 64 halves and compares all six read ports on every cycle, before the clock edge. A misrouted write is caught as soon as a random index lands on the damaged half. A bypass that wrongly forwards write data shows up in the same cycle as the write. Mode flips during the run reinterpret old contents, which exposes errors in the pairing logic that an even-only run would hide.

// File: rtl/fprf_pkg.sv
`timescale 1ns/1ps
package fprf_pkg;

  // Action taken on one temporary operand register in a cycle.
  typedef enum logic [1:0] {
    TMP_HOLD  = 2'd0,
    TMP_LOAD  = 2'd1,
    TMP_CLEAR = 2'd2
  } tmp_op_e;

endpackage

// File: rtl/fprf_storage.sv
`timescale 1ns/1ps
module fprf_storage #(
  parameter int DEPTH  = 32,
  parameter int HALF_W = 32,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           mode64,
  input  logic                           wr_w_en,
  input  logic [IDX_W-1:0]               wr_w_idx,
  input  logic [HALF_W-1:0]              wr_w_data,
  input  logic                           wr_d_en,
  input  logic [IDX_W-1:0]               wr_d_idx,
  input  logic [FULL_W-1:0]              wr_d_data,
  input  logic                           wr_u_en,
  input  logic [IDX_W-1:0]               wr_u_idx,
  input  logic [HALF_W-1:0]              wr_u_data,
  output logic [DEPTH-1:0][HALF_W-1:0]   lo_q,
  output logic [DEPTH-1:0][HALF_W-1:0]   hi_q
);

  logic [DEPTH-1:0][HALF_W-1:0] lo_n, hi_n;
  logic [IDX_W-1:0] pair_even, pair_odd;

  assign pair_even = {wr_d_idx[IDX_W-1:1], 1'b0};
  assign pair_odd  = {wr_d_idx[IDX_W-1:1], 1'b1};

  // Next-state decode: narrow writes first, doubleword last so it wins.
  always_comb begin
    lo_n = lo_q;
    hi_n = hi_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_u_en && wr_u_idx == IDX_W'(i)) hi_n[i] = wr_u_data;
      if (wr_w_en && wr_w_idx == IDX_W'(i)) lo_n[i] = wr_w_data;
      if (wr_d_en) begin
        if (mode64) begin
          if (wr_d_idx == IDX_W'(i)) begin
            lo_n[i] = wr_d_data[HALF_W-1:0];
            hi_n[i] = wr_d_data[FULL_W-1:HALF_W];
          end
        end else begin
          if (pair_even == IDX_W'(i)) lo_n[i] = wr_d_data[HALF_W-1:0];
          if (pair_odd  == IDX_W'(i)) lo_n[i] = wr_d_data[FULL_W-1:HALF_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (lo_q == '0 && hi_q == '0));

  assert_word_keeps_upper_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_w_en && !wr_d_en && !wr_u_en) |=>
      hi_q[$past(wr_w_idx)] == $past(hi_q[wr_w_idx]));

  assert_dword64_full_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_d_en && mode64) |=>
      {hi_q[$past(wr_d_idx)], lo_q[$past(wr_d_idx)]} == $past(wr_d_data));

  assert_dword32_split_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_d_en && !mode64) |=>
      (lo_q[{$past(wr_d_idx[IDX_W-1:1]), 1'b1}] == $past(wr_d_data[FULL_W-1:HALF_W]) &&
       lo_q[{$past(wr_d_idx[IDX_W-1:1]), 1'b0}] == $past(wr_d_data[HALF_W-1:0])));

  assert_dword32_upper_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_d_en && !mode64 && !wr_u_en) |=>
      hi_q[{$past(wr_d_idx[IDX_W-1:1]), 1'b0}] ==
        $past(hi_q[{wr_d_idx[IDX_W-1:1], 1'b0}]));

  assert_upper_keeps_low_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_u_en && !wr_w_en && !wr_d_en) |=>
      lo_q[$past(wr_u_idx)] == $past(lo_q[wr_u_idx]));

  assert_dword_beats_word_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_w_en && wr_d_en && !mode64 &&
     wr_w_idx[IDX_W-1:1] == wr_d_idx[IDX_W-1:1]) |=>
      lo_q[$past(wr_w_idx)] == ($past(wr_w_idx[0]) ? $past(wr_d_data[FULL_W-1:HALF_W])
                                                    : $past(wr_d_data[HALF_W-1:0])));

endmodule

// File: rtl/fprf_half_read.sv
`timescale 1ns/1ps
module fprf_half_read #(
  parameter int DEPTH  = 32,
  parameter int HALF_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]             idx,
  input  logic [DEPTH-1:0][HALF_W-1:0] bank,
  output logic [HALF_W-1:0]            data
);

  assign data = bank[idx];

endmodule

// File: rtl/fprf_pair_read.sv
`timescale 1ns/1ps
module fprf_pair_read #(
  parameter int DEPTH  = 32,
  parameter int HALF_W = 32,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic                         mode64,
  input  logic [IDX_W-1:0]             idx,
  input  logic [DEPTH-1:0][HALF_W-1:0] lo_q,
  input  logic [DEPTH-1:0][HALF_W-1:0] hi_q,
  output logic [FULL_W-1:0]            data
);

  logic [IDX_W-1:0] even_idx, odd_idx;

  assign even_idx = {idx[IDX_W-1:1], 1'b0};
  assign odd_idx  = {idx[IDX_W-1:1], 1'b1};

  always_comb begin
    if (mode64) data = {hi_q[idx], lo_q[idx]};
    else        data = {lo_q[odd_idx], lo_q[even_idx]};
  end

endmodule

// File: rtl/fprf_tmp_bank.sv
`timescale 1ns/1ps
module fprf_tmp_bank #(
  parameter int NTMP   = 3,
  parameter int FULL_W = 64,
  localparam int SEL_W = (NTMP > 1) ? $clog2(NTMP) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [SEL_W-1:0]             sel,
  input  logic                         load,
  input  logic                         clear,
  input  logic [FULL_W-1:0]            imm,
  output logic [NTMP-1:0][FULL_W-1:0]  q
);
  import fprf_pkg::*;

  tmp_op_e op;

  always_comb begin
    if (clear)     op = TMP_CLEAR;
    else if (load) op = TMP_LOAD;
    else           op = TMP_HOLD;
  end

  for (genvar t = 0; t < NTMP; t++) begin : g_tmp
    always_ff @(posedge clk) begin
      if (rst) begin
        q[t] <= '0;
      end else if (sel == SEL_W'(t)) begin
        case (op)
          TMP_CLEAR: q[t] <= '0;
          TMP_LOAD:  q[t] <= imm;
          default:   q[t] <= q[t];
        endcase
      end
    end
  end

  assert_tmp_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (clear && int'(sel) < NTMP) |=> q[$past(sel)] == '0);

  assert_tmp_load_R10: assert property (@(posedge clk) disable iff (rst)
    (load && !clear && int'(sel) < NTMP) |=> q[$past(sel)] == $past(imm));

  assert_tmp_reset_R1: assert property (@(posedge clk)
    rst |=> q == '0);

endmodule

// File: rtl/fp_regfile.sv
`timescale 1ns/1ps
module fp_regfile #(
  parameter int DEPTH  = 32,
  parameter int HALF_W = 32,
  parameter int NRD    = 2,
  parameter int NTMP   = 3,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int FULL_W = 2 * HALF_W,
  localparam int TSEL_W = (NTMP > 1) ? $clog2(NTMP) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          mode64,
  input  logic [NRD-1:0][IDX_W-1:0]     rd_w_idx,
  output logic [NRD-1:0][HALF_W-1:0]    rd_w_data,
  input  logic [NRD-1:0][IDX_W-1:0]     rd_d_idx,
  output logic [NRD-1:0][FULL_W-1:0]    rd_d_data,
  input  logic [NRD-1:0][IDX_W-1:0]     rd_u_idx,
  output logic [NRD-1:0][HALF_W-1:0]    rd_u_data,
  input  logic                          wr_w_en,
  input  logic [IDX_W-1:0]              wr_w_idx,
  input  logic [HALF_W-1:0]             wr_w_data,
  input  logic                          wr_d_en,
  input  logic [IDX_W-1:0]              wr_d_idx,
  input  logic [FULL_W-1:0]             wr_d_data,
  input  logic                          wr_u_en,
  input  logic [IDX_W-1:0]              wr_u_idx,
  input  logic [HALF_W-1:0]             wr_u_data,
  input  logic [TSEL_W-1:0]             tmp_sel,
  input  logic                          tmp_load,
  input  logic                          tmp_clear,
  input  logic [FULL_W-1:0]             tmp_imm,
  output logic [NTMP-1:0][FULL_W-1:0]   tmp_q
);

  logic [DEPTH-1:0][HALF_W-1:0] lo_q, hi_q;

  fprf_storage #(.DEPTH(DEPTH), .HALF_W(HALF_W)) u_store (
    .clk       (clk),
    .rst       (rst),
    .mode64    (mode64),
    .wr_w_en   (wr_w_en),
    .wr_w_idx  (wr_w_idx),
    .wr_w_data (wr_w_data),
    .wr_d_en   (wr_d_en),
    .wr_d_idx  (wr_d_idx),
    .wr_d_data (wr_d_data),
    .wr_u_en   (wr_u_en),
    .wr_u_idx  (wr_u_idx),
    .wr_u_data (wr_u_data),
    .lo_q      (lo_q),
    .hi_q      (hi_q)
  );

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    fprf_half_read #(.DEPTH(DEPTH), .HALF_W(HALF_W)) u_word (
      .idx  (rd_w_idx[p]),
      .bank (lo_q),
      .data (rd_w_data[p])
    );
    fprf_half_read #(.DEPTH(DEPTH), .HALF_W(HALF_W)) u_upper (
      .idx  (rd_u_idx[p]),
      .bank (hi_q),
      .data (rd_u_data[p])
    );
    fprf_pair_read #(.DEPTH(DEPTH), .HALF_W(HALF_W)) u_dword (
      .mode64 (mode64),
      .idx    (rd_d_idx[p]),
      .lo_q   (lo_q),
      .hi_q   (hi_q),
      .data   (rd_d_data[p])
    );
  end

  fprf_tmp_bank #(.NTMP(NTMP), .FULL_W(FULL_W)) u_tmp (
    .clk   (clk),
    .rst   (rst),
    .sel   (tmp_sel),
    .load  (tmp_load),
    .clear (tmp_clear),
    .imm   (tmp_imm),
    .q     (tmp_q)
  );

endmodule

// File: tb/fp_regfile_test.sv
`timescale 1ns/1ps
module fp_regfile_test;

  localparam int DEPTH = 32, HW = 32, FW = 64, NRD = 2, NTMP = 3, IW = 5, TW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode64 = 1'b1;
  logic [NRD-1:0][IW-1:0] rd_w_idx = '0, rd_d_idx = '0, rd_u_idx = '0;
  logic [NRD-1:0][HW-1:0] rd_w_data, rd_u_data;
  logic [NRD-1:0][FW-1:0] rd_d_data;
  logic wr_w_en = 0, wr_d_en = 0, wr_u_en = 0;
  logic [IW-1:0] wr_w_idx = '0, wr_d_idx = '0, wr_u_idx = '0;
  logic [HW-1:0] wr_w_data = '0, wr_u_data = '0;
  logic [FW-1:0] wr_d_data = '0;
  logic [TW-1:0] tmp_sel = '0;
  logic tmp_load = 0, tmp_clear = 0;
  logic [FW-1:0] tmp_imm = '0;
  logic [NTMP-1:0][FW-1:0] tmp_q;

  fp_regfile uut (.*);

  always #2.5 clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  logic [HW-1:0] mlo [DEPTH];
  logic [HW-1:0] mhi [DEPTH];
  logic [FW-1:0] mtmp [NTMP];

  task automatic check(string req, logic [FW-1:0] act, logic [FW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [FW-1:0] exp_dword(logic m, logic [IW-1:0] i);
    if (m) return {mhi[i], mlo[i]};
    return {mlo[{i[IW-1:1], 1'b1}], mlo[{i[IW-1:1], 1'b0}]};
  endfunction

  task automatic check_reads(string tag);
    for (int p = 0; p < NRD; p++) begin
      check(tag == "" ? "R2" : tag, {32'h0, rd_w_data[p]}, {32'h0, mlo[rd_w_idx[p]]});
      check(tag == "" ? (mode64 ? "R3" : "R4") : tag, rd_d_data[p], exp_dword(mode64, rd_d_idx[p]));
      check(tag == "" ? "R7" : tag, {32'h0, rd_u_data[p]}, {32'h0, mhi[rd_u_idx[p]]});
    end
    for (int t = 0; t < NTMP; t++) check(tag == "" ? "R10" : tag, tmp_q[t], mtmp[t]);
  endtask

  // Reference update from the requirements: narrow writes, then doubleword (R8).
  task automatic model_update();
    logic [HW-1:0] nlo [DEPTH];
    logic [HW-1:0] nhi [DEPTH];
    nlo = mlo; nhi = mhi;
    if (wr_u_en) nhi[wr_u_idx] = wr_u_data;
    if (wr_w_en) nlo[wr_w_idx] = wr_w_data;
    if (wr_d_en) begin
      if (mode64) begin
        nlo[wr_d_idx] = wr_d_data[31:0];
        nhi[wr_d_idx] = wr_d_data[63:32];
      end else begin
        nlo[{wr_d_idx[IW-1:1], 1'b0}] = wr_d_data[31:0];
        nlo[{wr_d_idx[IW-1:1], 1'b1}] = wr_d_data[63:32];
      end
    end
    mlo = nlo; mhi = nhi;
    if (int'(tmp_sel) < NTMP) begin
      if (tmp_clear) mtmp[tmp_sel] = '0;
      else if (tmp_load) mtmp[tmp_sel] = tmp_imm;
    end
  endtask

  // Called just after a falling edge with inputs already driven.
  task automatic tick(string tag);
    #1 check_reads(tag);
    @(posedge clk);
    #0.5 model_update();
    @(negedge clk);
  endtask

  task automatic idle();
    wr_w_en = 0; wr_d_en = 0; wr_u_en = 0; tmp_load = 0; tmp_clear = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    #750000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < DEPTH; i++) begin mlo[i] = '0; mhi[i] = '0; end
    for (int t = 0; t < NTMP; t++) mtmp[t] = '0;
    // Leave junk on the write inputs during reset; reset must still clear.
    wr_w_en = 1; wr_w_data = 32'hDEAD_BEEF; tmp_load = 1; tmp_imm = '1;
    repeat (3) @(negedge clk);
    rst = 0; idle();
    // R1: sweep every entry through all read kinds
    for (int i = 0; i < DEPTH; i++) begin
      rd_w_idx = {2{IW'(i)}}; rd_d_idx = {2{IW'(i)}}; rd_u_idx = {2{IW'(i)}};
      #1 check_reads("R1");
      #0.1;
    end
    @(negedge clk);

    // R3 then R2: full write, then word write keeps upper
    mode64 = 1;
    wr_d_en = 1; wr_d_idx = 5'd4; wr_d_data = 64'h1111_2222_3333_4444;
    tick("R3"); idle();
    wr_w_en = 1; wr_w_idx = 5'd4; wr_w_data = 32'hAAAA_5555;
    rd_d_idx = {5'd4, 5'd4};
    tick("R2"); idle();
    rd_d_idx = {5'd4, 5'd5}; rd_u_idx = {5'd4, 5'd4}; rd_w_idx = {5'd4, 5'd4};
    tick("R2");

    // R5/R6: pair write through odd index, upper halves kept
    mode64 = 0;
    wr_u_en = 1; wr_u_idx = 5'd6; wr_u_data = 32'h6666_0000; tick("R7"); idle();
    wr_d_en = 1; wr_d_idx = 5'd7; wr_d_data = 64'hCAFE_0007_BABE_0006;
    tick("R5"); idle();
    rd_d_idx = {5'd6, 5'd7}; rd_w_idx = {5'd6, 5'd7}; rd_u_idx = {5'd6, 5'd7};
    tick("R6");
    tick("R5");

    // R8: word and upper collide with doubleword
    wr_w_en = 1; wr_w_idx = 5'd6; wr_w_data = 32'h0BAD_0BAD;
    wr_d_en = 1; wr_d_idx = 5'd6; wr_d_data = 64'h0123_4567_89AB_CDEF;
    tick("R8"); idle();
    tick("R8");
    mode64 = 1;
    wr_u_en = 1; wr_u_idx = 5'd9; wr_u_data = 32'hFFFF_0000;
    wr_d_en = 1; wr_d_idx = 5'd9; wr_d_data = 64'h9999_8888_7777_6666;
    rd_d_idx = {5'd9, 5'd9}; rd_u_idx = {5'd9, 5'd9};
    tick("R9"); idle();
    tick("R8");

    // R9: read same entry being written
    wr_w_en = 1; wr_w_idx = 5'd9; wr_w_data = 32'h1234_5678; rd_w_idx = {5'd9, 5'd9};
    tick("R9"); idle();
    tick("R9");

    // R10: load, clear-wins, out-of-range select
    tmp_sel = 2'd1; tmp_load = 1; tmp_imm = 64'hFEED_FACE_0000_0001; tick("R10");
    tmp_sel = 2'd2; tmp_imm = 64'h2; tick("R10");
    tmp_sel = 2'd1; tmp_clear = 1; tick("R10");
    tmp_sel = 2'd3; tmp_clear = 0; tmp_imm = '1; tick("R10");
    idle(); tick("R10");

    // Random mixed traffic
    for (int n = 0; n < 6000; n++) begin
      if (n % 250 == 0) mode64 = $urandom_range(0, 1);
      wr_w_en = ($urandom_range(0, 2) == 0); wr_w_idx = IW'($urandom); wr_w_data = $urandom;
      wr_d_en = ($urandom_range(0, 2) == 0); wr_d_idx = IW'($urandom); wr_d_data = {$urandom, $urandom};
      wr_u_en = ($urandom_range(0, 2) == 0); wr_u_idx = IW'($urandom); wr_u_data = $urandom;
      if ($urandom_range(0, 3) == 0) begin wr_w_idx = wr_d_idx; wr_u_idx = wr_d_idx ^ 5'd1; end
      for (int p = 0; p < NRD; p++) begin
        rd_w_idx[p] = IW'($urandom); rd_d_idx[p] = IW'($urandom); rd_u_idx[p] = IW'($urandom);
      end
      if ($urandom_range(0, 3) == 0) rd_d_idx[0] = wr_d_idx;
      tmp_sel = TW'($urandom); tmp_load = ($urandom_range(0, 3) == 0);
      tmp_clear = ($urandom_range(0, 7) == 0); tmp_imm = {$urandom, $urandom};
      tick("");
    end
    idle(); tick("");

    done = 1;
    summary();
    $finish;
  end

endmodule